// File: doc/BRIEF.md
# Dual-Channel Front-End Data Synchronizer

This block sits between two charge-integrating front-end channels and a serial link driver. It runs on the bunch-crossing clock. On every crossing each channel delivers a 9-bit digitized word: a mantissa, a range exponent and a capacitor-rotation ID. The block merges the two words into one registered 32-bit output word for the serializer.

While it merges, the block watches data integrity. The two capacitor IDs must agree, and each must step forward by one every crossing. A crossing counter runs alongside the data and is checked whenever the orbit marker arrives.

Control inputs can force the range field to a chosen value or replace the data with a fixed test pattern. A separate request arms a front-end reset, which the block releases only at a predetermined crossing. Errors are held and sent to the link in one fixed crossing slot per orbit. They are not sent at the moment they occur.

Top module: `fe_sync_merge`

## Requirements
- R1: Each input word is laid out as capacitor ID in bits [8:7], range in bits [6:5] and mantissa in bits [4:0]. The output word carries the following fields, all registered so that they appear one clock after the inputs they come from:
  - channel 0 field in bits [8:0]
  - channel 1 field in bits [17:9]
  - the channel-0 capacitor ID in bits [19:18]
  - the error bit in bit 20
  - the pattern-mode flag in bit 21
  - zeros in bits [31:22]
- R2: While `range_force_en` is high, the range field of both channels in the output is replaced by `range_force_val`. Mantissa and capacitor ID pass through unchanged.
- R3: While `pattern_en` is high, output bits [19:0] hold the parameter `TEST_PATTERN` (default 20'hA5C3F) and bit 21 is 1. The error bit still follows R7.
- R4: A crossing in which the two channels' capacitor IDs differ is recorded as an error.
- R5: A crossing in which either channel's capacitor ID is not its previous value plus one (modulo 4) is recorded as an error. The first crossing after reset is exempt from this check.
- R6: The crossing counter starts at 0 after reset, counts up by one per clock and wraps from `ORBIT_LEN`-1 to 0. An orbit marker must arrive while the count is 0. A marker at any other count is recorded as an error, and the counter realigns so that the marker's crossing counts as 0.
- R7: Recorded errors are held until the crossing whose count equals `REPORT_SLOT`. The output word for that crossing carries the error bit. The held errors are then cleared. The error bit is 0 in every other output word. An error recorded in the slot crossing itself is held for the next slot.
- R8: A pulse on `fe_reset_req` arms a front-end reset. `fe_reset_out` then goes high for exactly one clock, aligned with the output word of the next crossing whose count equals `RESET_SLOT`. A request made after that slot waits for the following orbit.
- R9: While `rst` is high, `out_word` and `fe_reset_out` are 0. The counter, the held errors and any armed reset request are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| ch0_word | input | 9 | Channel 0 word: capacitor ID, range, mantissa |
| ch1_word | input | 9 | Channel 1 word, same layout |
| orbit_mark | input | 1 | Orbit marker, expected at count 0 |
| pattern_en | input | 1 | Send the fixed test pattern instead of data |
| range_force_en | input | 1 | Override the range field of both channels |
| range_force_val | input | 2 | Range value used while forcing |
| fe_reset_req | input | 1 | Arms a front-end reset for the next reset slot |
| out_word | output | 32 | Merged, registered word toward the serializer |
| fe_reset_out | output | 1 | One-clock front-end reset pulse |

## Verification
On every cycle, the assertions check the following:
- the crossing counter stays in range, wraps and realigns after a marker
- a held error persists until its slot
- the error bit and the front-end reset pulse only ever follow their own slot crossings
- pattern mode always yields the fixed pattern

Only the bench scenarios can show that particular faults end up reported: a capacitor-ID disagreement, a skipped capacitor-ID step and a misplaced orbit marker. They also show the following:
- the slot falls where it should after a realignment
- the held error clears after it is sent
- a reset request made late in an orbit fires in the next one
- forced ranges and channel fields land in the right bit positions

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int MANT_W  = 5;
  localparam int RANGE_W = 2;
  localparam int CAP_W   = 2;
  localparam int NCH     = 2;
  localparam int CH_W    = MANT_W + RANGE_W + CAP_W;
  localparam int DATA_W  = NCH * CH_W + CAP_W;
  localparam int OUT_W   = 32;
  localparam int PAD_W   = OUT_W - DATA_W - 2;

  typedef struct packed {
    logic [CAP_W-1:0]   capid;
    logic [RANGE_W-1:0] rng;
    logic [MANT_W-1:0]  mant;
  } chan_t;
endpackage

// File: rtl/fes_bx_counter.sv
module fes_bx_counter #(
  parameter int ORBIT_LEN = 3564,
  localparam int BX_W = $clog2(ORBIT_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            orbit_mark,
  output logic [BX_W-1:0] bx,
  output logic            sync_err
);
  localparam logic [BX_W-1:0] LAST = BX_W'(ORBIT_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst)             bx <= '0;
    else if (orbit_mark) bx <= BX_W'(1);
    else if (bx == LAST) bx <= '0;
    else                 bx <= bx + 1'b1;
  end

  // a marker is only legal while the count sits at zero
  assign sync_err = orbit_mark && (bx != '0);

  p_bx_range_r6: assert property (@(posedge clk) disable iff (rst) bx <= LAST);
  p_bx_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (bx == LAST && !orbit_mark) |=> bx == '0);
  p_bx_realign_r6: assert property (@(posedge clk) disable iff (rst)
    orbit_mark |=> bx == BX_W'(1));
endmodule

// File: rtl/fes_capid_check.sv
module fes_capid_check
  import fes_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NCH-1:0][CH_W-1:0]  chans,
  output logic                      cap_err
);
  logic [NCH-1:0] step_bad;
  logic [NCH-1:0] differs;
  logic           armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_t            cur;
    chan_t            ref0;
    logic [CAP_W-1:0] prev;

    assign cur  = chans[i];
    assign ref0 = chans[0];

    always_ff @(posedge clk) begin
      if (rst) prev <= '0;
      else     prev <= cur.capid;
    end

    assign step_bad[i] = armed && (cur.capid != CAP_W'(prev + 1'b1));
    assign differs[i]  = (cur.capid != ref0.capid);
  end

  assign cap_err = (|differs) | (|step_bad);

  p_first_exempt_r5: assert property (@(posedge clk) disable iff (rst)
    !armed |-> step_bad == '0);
endmodule

// File: rtl/fes_err_report.sv
module fes_err_report (
  input  logic clk,
  input  logic rst,
  input  logic cap_err,
  input  logic sync_err,
  input  logic at_slot,
  output logic report
);
  logic held;

  // a new error wins over the clear of the slot crossing
  always_ff @(posedge clk) begin
    if (rst) held <= 1'b0;
    else     held <= cap_err | sync_err | (held & ~at_slot);
  end

  assign report = held & at_slot;

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (held && !at_slot) |=> held);
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (cap_err || sync_err) |=> held);
endmodule

// File: rtl/fes_fe_reset.sv
module fes_fe_reset (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic at_slot,
  output logic pulse
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pend  <= req | (pend & ~at_slot);
      pulse <= pend & at_slot;
    end
  end

  p_pulse_slot_r8: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(at_slot) && $past(pend));
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/fes_pack.sv
module fes_pack
  import fes_pkg::*;
#(
  parameter logic [DATA_W-1:0] TEST_PATTERN = 20'hA5C3F
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NCH-1:0][CH_W-1:0] chans,
  input  logic                     pattern_en,
  input  logic                     force_en,
  input  logic [RANGE_W-1:0]       force_val,
  input  logic                     report,
  input  logic                     report_slot,
  output logic [OUT_W-1:0]         out_word
);
  logic [NCH-1:0][CH_W-1:0] fld;
  chan_t                    lead;
  logic                     live;

  assign lead = chans[0];

  for (genvar i = 0; i < NCH; i++) begin : g_fld
    chan_t c_in;
    assign c_in   = chans[i];
    assign fld[i] = {c_in.capid, (force_en ? force_val : c_in.rng), c_in.mant};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word <= '0;
      live     <= 1'b0;
    end else begin
      live <= 1'b1;
      if (pattern_en) out_word <= {{PAD_W{1'b0}}, 1'b1, report, TEST_PATTERN};
      else            out_word <= {{PAD_W{1'b0}}, 1'b0, report, lead.capid, fld};
    end
  end

  p_pattern_r3: assert property (@(posedge clk) disable iff (rst)
    (live && $past(pattern_en)) |-> (out_word[DATA_W-1:0] == TEST_PATTERN && out_word[DATA_W+1]));
  p_err_slot_r7: assert property (@(posedge clk) disable iff (rst)
    out_word[DATA_W] |-> $past(report_slot));
  p_pad_zero_r1: assert property (@(posedge clk) disable iff (rst)
    out_word[OUT_W-1:DATA_W+2] == '0);
endmodule

// File: rtl/fe_sync_merge.sv
module fe_sync_merge
  import fes_pkg::*;
#(
  parameter int                ORBIT_LEN    = 3564,
  parameter int                REPORT_SLOT  = 3,
  parameter int                RESET_SLOT   = 2,
  parameter logic [DATA_W-1:0] TEST_PATTERN = 20'hA5C3F,
  localparam int BX_W = $clog2(ORBIT_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CH_W-1:0]    ch0_word,
  input  logic [CH_W-1:0]    ch1_word,
  input  logic               orbit_mark,
  input  logic               pattern_en,
  input  logic               range_force_en,
  input  logic [RANGE_W-1:0] range_force_val,
  input  logic               fe_reset_req,
  output logic [OUT_W-1:0]   out_word,
  output logic               fe_reset_out
);
  logic [NCH-1:0][CH_W-1:0] chans;
  logic [BX_W-1:0]          bx;
  logic                     sync_err;
  logic                     cap_err;
  logic                     report;
  logic                     at_report;
  logic                     at_reset;

  assign chans     = {ch1_word, ch0_word};
  assign at_report = (bx == BX_W'(REPORT_SLOT));
  assign at_reset  = (bx == BX_W'(RESET_SLOT));

  fes_bx_counter #(.ORBIT_LEN(ORBIT_LEN)) u_cnt (
    .clk(clk), .rst(rst), .orbit_mark(orbit_mark), .bx(bx), .sync_err(sync_err)
  );

  fes_capid_check u_cap (
    .clk(clk), .rst(rst), .chans(chans), .cap_err(cap_err)
  );

  fes_err_report u_err (
    .clk(clk), .rst(rst), .cap_err(cap_err), .sync_err(sync_err),
    .at_slot(at_report), .report(report)
  );

  fes_fe_reset u_rst (
    .clk(clk), .rst(rst), .req(fe_reset_req), .at_slot(at_reset), .pulse(fe_reset_out)
  );

  fes_pack #(.TEST_PATTERN(TEST_PATTERN)) u_pack (
    .clk(clk), .rst(rst), .chans(chans), .pattern_en(pattern_en),
    .force_en(range_force_en), .force_val(range_force_val),
    .report(report), .report_slot(at_report), .out_word(out_word)
  );

  p_reset_quiet_r9: assert property (@(posedge clk)
    $past(rst) |-> (out_word == '0 && !fe_reset_out));
endmodule

// File: tb/fe_sync_merge_bench.sv
module fe_sync_merge_bench;
  localparam int L    = 16;
  localparam int RPT  = 5;
  localparam int RSL  = 10;
  localparam logic [19:0] PAT = 20'hA5C3F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  ch0_word = '0, ch1_word = '0;
  logic        orbit_mark = 0, pattern_en = 0, range_force_en = 0, fe_reset_req = 0;
  logic [1:0]  range_force_val = '0;
  logic [31:0] out_word;
  logic        fe_reset_out;

  int checks = 0, errors = 0, bx_b = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fe_sync_merge #(.ORBIT_LEN(L), .REPORT_SLOT(RPT), .RESET_SLOT(RSL), .TEST_PATTERN(PAT)) u_fe_sync_merge (
    .clk(clk), .rst(rst), .ch0_word(ch0_word), .ch1_word(ch1_word),
    .orbit_mark(orbit_mark), .pattern_en(pattern_en), .range_force_en(range_force_en),
    .range_force_val(range_force_val), .fe_reset_req(fe_reset_req),
    .out_word(out_word), .fe_reset_out(fe_reset_out)
  );

  typedef struct packed {
    logic [8:0] a, b;
    logic       pat, fen;
    logic [1:0] fv;
    logic [8:0] ea, eb;
    logic [1:0] ecap;
    logic       epat;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{{2'd0,2'd1,5'd7},  {2'd0,2'd2,5'd31}, 1'b0, 1'b0, 2'd0, {2'd0,2'd1,5'd7},  {2'd0,2'd2,5'd31}, 2'd0, 1'b0},
    '{{2'd1,2'd3,5'd0},  {2'd1,2'd0,5'd16}, 1'b0, 1'b1, 2'd2, {2'd1,2'd2,5'd0},  {2'd1,2'd2,5'd16}, 2'd1, 1'b0},
    '{{2'd2,2'd0,5'd21}, {2'd2,2'd3,5'd10}, 1'b1, 1'b0, 2'd0, 9'd0, 9'd0, 2'd0, 1'b1},
    '{{2'd3,2'd2,5'd5},  {2'd3,2'd1,5'd9},  1'b0, 1'b1, 2'd0, {2'd3,2'd0,5'd5},  {2'd3,2'd0,5'd9},  2'd3, 1'b0},
    '{{2'd0,2'd1,5'd1},  {2'd0,2'd1,5'd2},  1'b0, 1'b0, 2'd0, {2'd0,2'd1,5'd1},  {2'd0,2'd1,5'd2},  2'd0, 1'b0},
    '{{2'd1,2'd2,5'd3},  {2'd1,2'd3,5'd4},  1'b1, 1'b1, 2'd1, 9'd0, 9'd0, 2'd0, 1'b1},
    '{{2'd2,2'd3,5'd31}, {2'd2,2'd3,5'd31}, 1'b0, 1'b1, 2'd3, {2'd2,2'd3,5'd31}, {2'd2,2'd3,5'd31}, 2'd2, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one crossing at the falling edge, return at the next falling edge
  task automatic xing(input logic [8:0] a, b, input logic mark, pat, fen,
                      input logic [1:0] fv, input logic req);
    ch0_word = a; ch1_word = b; orbit_mark = mark; pattern_en = pat;
    range_force_en = fen; range_force_val = fv; fe_reset_req = req;
    @(negedge clk);
    bx_b = mark ? 1 : ((bx_b == L-1) ? 0 : bx_b + 1);
    orbit_mark = 0; fe_reset_req = 0;
  endtask

  task automatic cyc(input logic [1:0] c0, c1, input logic mark, input logic req);
    xing({c0, 2'd0, 5'd0}, {c1, 2'd0, 5'd0}, mark, 1'b0, 1'b0, 2'd0, req);
  endtask

  task automatic do_reset();
    rst = 1;
    ch0_word = '0; ch1_word = '0; orbit_mark = 0; pattern_en = 0;
    range_force_en = 0; range_force_val = '0; fe_reset_req = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    bx_b = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] cv;
    int mis;
    @(negedge clk);
    do_reset();
    // R9: quiet outputs while reset is held
    rst = 1; pattern_en = 1; fe_reset_req = 1;
    repeat (2) @(negedge clk);
    chk("R9 out_word in reset", out_word, 32'd0);
    chk("R9 fe_reset_out in reset", {31'd0, fe_reset_out}, 32'd0);
    do_reset();

    // R1 R2 R3: table walk, error bit masked
    for (int i = 0; i < 7; i++) begin
      logic [31:0] exp;
      xing(TBL[i].a, TBL[i].b, 1'b0, TBL[i].pat, TBL[i].fen, TBL[i].fv, 1'b0);
      exp = TBL[i].epat ? {10'd0, 1'b1, 1'b0, PAT}
                        : {10'd0, 1'b0, 1'b0, TBL[i].ecap, TBL[i].eb, TBL[i].ea};
      chk($sformatf("R1 R2 R3 vector %0d", i), out_word & ~32'h0010_0000, exp);
    end

    // R4 R7: capacitor-ID disagreement at crossing 1
    do_reset();
    for (int k = 0; k < 16; k++) begin
      cyc(2'(k % 4), (k == 1) ? 2'd2 : 2'(k % 4), 1'b0, 1'b0);
      if (k == 2) chk("R7 no report before slot", {31'd0, out_word[20]}, 32'd0);
      if (k == 5) chk("R4 mismatch reported at slot", {31'd0, out_word[20]}, 32'd1);
    end
    for (int k = 0; k < 6; k++) begin
      cyc(2'(k % 4), 2'(k % 4), 1'b0, 1'b0);
      if (k == 5) chk("R7 cleared after report", {31'd0, out_word[20]}, 32'd0);
    end

    // R5: first crossing exempt, later skipped step reported
    do_reset();
    for (int k = 0; k < 16; k++) begin
      cv = (k < 8) ? 2'((k + 3) % 4) : 2'(k % 4);
      cyc(cv, cv, 1'b0, 1'b0);
      if (k == 5) chk("R5 first crossing exempt", {31'd0, out_word[20]}, 32'd0);
    end
    for (int k = 0; k < 6; k++) begin
      cyc(2'(k % 4), 2'(k % 4), 1'b0, 1'b0);
      if (k == 5) chk("R5 skipped step reported", {31'd0, out_word[20]}, 32'd1);
    end

    // R6: correct marker silent, misplaced marker reported, counter realigned
    do_reset();
    cv = 0;
    for (int k = 0; k < 9; k++) begin
      cyc(cv, cv, (k == 0 || k == 8), 1'b0);
      cv = cv + 1'b1;
      if (k == 5) chk("R6 marker at zero silent", {31'd0, out_word[20]}, 32'd0);
    end
    mis = 0;
    for (int k = 0; k < 5; k++) begin
      int b_in;
      b_in = bx_b;
      cyc(cv, cv, 1'b0, 1'b0);
      cv = cv + 1'b1;
      if (out_word[20] !== (b_in == RPT)) mis++;
    end
    chk("R6 realigned slot carries error", mis, 0);

    // R8: reset request pulses at slot, late request waits an orbit
    do_reset();
    mis = 0;
    for (int k = 0; k < 16; k++) begin
      cyc(2'(k % 4), 2'(k % 4), 1'b0, (k == 0 || k == 12));
      if (fe_reset_out !== (k == RSL)) mis++;
    end
    chk("R8 pulse only at reset slot", mis, 0);
    mis = 0;
    for (int k = 0; k < 16; k++) begin
      cyc(2'(k % 4), 2'(k % 4), 1'b0, 1'b0);
      if (fe_reset_out !== (k == RSL)) mis++;
    end
    chk("R8 late request fires next orbit", mis, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule